// File: doc/BRIEF.md
# Receive Character Buffer with Idle Timeout

This block sits behind a serial receiver and holds received characters until the host collects them. When buffering is on, characters go into a 16-deep first-in first-out store. A data-available interrupt is raised once the number of stored characters reaches a selectable trigger level. A character-timeout interrupt is raised when characters have waited in the store without new arrivals or host reads for longer than a window that grows with the word length. When buffering is off, the store acts as a single holding register.

The host sees the oldest character on the read-data port at all times. It pulls that character with a read strobe and can poll the data-ready flag to learn whether more remain. A write that arrives when the store is full is dropped and latches a sticky overrun flag, which the host clears by reading status. A clear input empties the store and drops both interrupts in one cycle. The serial deserializer, baud timing and register decode live outside this block.

Top module: `rx_fifo_timeout`

## Requirements
- R1: With `fifo_en_i`=1, up to 16 characters are stored. `rd_data_o` always shows the oldest stored character, and a `rd_i` pulse removes it, so characters leave in arrival order.
- R2: `fill_o` equals the number of stored characters. `data_ready_o` is 1 exactly when `fill_o` is nonzero.
- R3: Trigger code `trig_sel_i` 0, 1, 2, 3 selects levels 1, 4, 8, 14. `data_avail_irq_o` is 1 when `rx_int_en_i`=1 and `fill_o` is at or above the level.
- R4: A `char_valid_i` while `fill_o` equals the capacity drops the byte and sets `overrun_o` on the next cycle. A `status_rd_i` pulse clears `overrun_o` on the next cycle, and a new drop in the same cycle wins.
- R5: Word-length code `word_len_i` 0, 1, 2, 3 means 5, 6, 7, 8 data bits (P). The timeout flag sets on the cycle after the (4·P+12)-th `bit_tick_i` pulse counted since the last restart while the store was non-empty: 32, 36, 40 or 44 ticks.
- R6: A `stop_mid_i` pulse restarts the timeout count. While the store is empty, nothing is counted and `timeout_irq_o` stays 0.
- R7: A `rd_i` pulse restarts the timeout count and clears the timeout flag. The flag can return only after a full window.
- R8: `rx_int_en_i`=0 forces both `data_avail_irq_o` and `timeout_irq_o` to 0.
- R9: With `fifo_en_i`=0, the capacity is 1, the trigger level is 1 whatever `trig_sel_i` says, and no timeout is generated.
- R10: A `fifo_clr_i` pulse empties the store, zeroes the timeout count and clears both interrupts by the next cycle. `overrun_o` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | Received character strobe |
| char_data_i | input | 8 | Received character |
| stop_mid_i | input | 1 | Middle of a received stop bit |
| bit_tick_i | input | 1 | One pulse per bit time |
| word_len_i | input | 2 | Data bits code, 0..3 = 5..8 |
| trig_sel_i | input | 2 | Trigger code, 0..3 = 1,4,8,14 |
| fifo_en_i | input | 1 | 1 = 16-deep buffering, 0 = single register |
| rx_int_en_i | input | 1 | Receive interrupt enable |
| fifo_clr_i | input | 1 | Empty store and clear interrupts |
| rd_i | input | 1 | Host read of the oldest character |
| status_rd_i | input | 1 | Host read of status, clears overrun |
| rd_data_o | output | 8 | Oldest stored character |
| data_ready_o | output | 1 | Store not empty |
| fill_o | output | 5 | Stored character count |
| overrun_o | output | 1 | Sticky drop flag |
| data_avail_irq_o | output | 1 | Trigger level reached |
| timeout_irq_o | output | 1 | Character timeout |

## Verification
The bench counts timeout ticks one by one for three word lengths. It checks that the flag stays low after one tick short of the window and rises on the last tick. A design with an off-by-one window, or a wrong 4·P+12 mapping, fails there. Stop-bit and host-read restarts fall between ticks, so a timer that ignores them fires early. The store is filled to exactly 16 and then pushed once more, and the bench checks data order across the pointer wrap: a full-detection bug would corrupt the count or overwrite the oldest byte. The single-register mode is driven with trigger code 3 still set, which exposes a design that keeps the programmed level or keeps timing out.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // window in bit times: 4 * data bits + 12
  function automatic int timeout_bits(input logic [1:0] wl);
    return 4 * (int'(wl) + 5) + 12;
  endfunction
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          clr_i,
  input  logic [CW-1:0] cap_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          drop_o,
  output logic          pop_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push;

  assign pop_o   = rd_i && (cnt_q != '0) && !clr_i;
  assign push    = wr_i && (cnt_q < cap_i) && !clr_i;
  assign drop_o  = wr_i && (cnt_q >= cap_i) && !clr_i;
  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_o) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({push, pop_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (push && wp_q == AW'(g)) mem_q[g] <= wdata_i;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R1
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && !clr_i && cnt_q == cap_i) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/rx_char_timer.sv
module rx_char_timer #(
  parameter int TW = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic       flag_clr_i,
  input  logic       enable_i,
  input  logic [1:0] word_len_i,
  output logic       flag_o
);
  import rx_fifo_pkg::*;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] last;
  logic          run;

  assign last = TW'(timeout_bits(word_len_i) - 1);
  assign run  = enable_i && !flag_o && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (restart_i || !enable_i) cnt_q <= '0;
      else if (run && tick_i) cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;

      if (flag_clr_i || !enable_i) flag_o <= 1'b0;
      else if (run && tick_i && cnt_q >= last) flag_o <= 1'b1;
    end
  end

  AST_TO_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i |=> !flag_o); // R7
  AST_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !flag_o); // R6
endmodule

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TW    = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          char_valid_i,
  input  logic [DW-1:0] char_data_i,
  input  logic          stop_mid_i,
  input  logic          bit_tick_i,
  input  logic [1:0]    word_len_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          fifo_en_i,
  input  logic          rx_int_en_i,
  input  logic          fifo_clr_i,
  input  logic          rd_i,
  input  logic          status_rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          data_ready_o,
  output logic [CW-1:0] fill_o,
  output logic          overrun_o,
  output logic          data_avail_irq_o,
  output logic          timeout_irq_o
);
  import rx_fifo_pkg::*;

  logic [CW-1:0] cap, level, count;
  logic          drop, pop, to_flag, tmr_en, tmr_restart;

  assign cap   = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign level = fifo_en_i ? CW'(trig_level(trig_sel_i)) : CW'(1);

  rx_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (char_valid_i),
    .wdata_i (char_data_i),
    .rd_i    (rd_i),
    .clr_i   (fifo_clr_i),
    .cap_i   (cap),
    .rdata_o (rd_data_o),
    .count_o (count),
    .drop_o  (drop),
    .pop_o   (pop)
  );

  assign tmr_en      = fifo_en_i && (count != '0);
  assign tmr_restart = stop_mid_i || rd_i || fifo_clr_i;

  rx_char_timer #(.TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (bit_tick_i),
    .restart_i  (tmr_restart),
    .flag_clr_i (rd_i || fifo_clr_i),
    .enable_i   (tmr_en),
    .word_len_i (word_len_i),
    .flag_o     (to_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overrun_o <= 1'b0;
    else if (drop) overrun_o <= 1'b1;
    else if (status_rd_i) overrun_o <= 1'b0;
  end

  assign fill_o           = count;
  assign data_ready_o     = count != '0;
  assign data_avail_irq_o = rx_int_en_i && (count >= level);
  assign timeout_irq_o    = rx_int_en_i && to_flag;

  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> overrun_o); // R4
  AST_TO_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_flag |-> count != '0); // R6
  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> (count == '0) && !to_flag); // R10
  AST_SINGLE_NO_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> !to_flag); // R9
  AST_POP_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !char_valid_i) |=> count == $past(count) - 1'b1); // R1
endmodule

// File: tb/rx_fifo_timeout_test.sv
module rx_fifo_timeout_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_valid = 0, stop_mid = 0, bit_tick = 0;
  logic [7:0] char_data = 0;
  logic [1:0] word_len = 2'd2, trig_sel = 2'd1;
  logic       fifo_en = 1, rx_int_en = 1, fifo_clr = 0, rd = 0, status_rd = 0;
  logic [7:0] rd_data;
  logic       data_ready, overrun, avail_irq, to_irq;
  logic [4:0] fill;

  int checks = 0, fails = 0;
  logic [7:0] sb_q[$];

  always #4 clk = ~clk;

  rx_fifo_timeout uut (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(char_valid), .char_data_i(char_data),
    .stop_mid_i(stop_mid), .bit_tick_i(bit_tick), .word_len_i(word_len),
    .trig_sel_i(trig_sel), .fifo_en_i(fifo_en), .rx_int_en_i(rx_int_en),
    .fifo_clr_i(fifo_clr), .rd_i(rd), .status_rd_i(status_rd), .rd_data_o(rd_data),
    .data_ready_o(data_ready), .fill_o(fill), .overrun_o(overrun),
    .data_avail_irq_o(avail_irq), .timeout_irq_o(to_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: pushes a byte and records it when the model has room
  task automatic push(input logic [7:0] b);
    int cap = fifo_en ? 16 : 1;
    char_valid = 1; char_data = b;
    @(negedge clk);
    char_valid = 0;
    if (sb_q.size() < cap) sb_q.push_back(b);
  endtask

  // monitor: compares the oldest byte against the scoreboard, then pops
  task automatic pop(input string req);
    logic [7:0] exp = sb_q.pop_front();
    check(req, int'(rd_data), int'(exp));
    rd = 1;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; @(negedge clk);
      bit_tick = 0; @(negedge clk);
    end
  endtask

  task automatic pulse_stop;
    stop_mid = 1; @(negedge clk); stop_mid = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2 reset fill", fill, 0);
    check("R2 reset ready", data_ready, 0);
    check("R8 reset irqs", {avail_irq, to_irq}, 0);
    check("R4 reset overrun", overrun, 0);

    // trigger 4, 7-bit words -> 40 ticks
    for (int i = 0; i < 3; i++) push(8'h10 + 8'(i));
    check("R2 fill 3", fill, 3);
    check("R2 ready", data_ready, 1);
    check("R3 below level 4", avail_irq, 0);
    push(8'h13);
    check("R3 at level 4", avail_irq, 1);
    ticks(39);
    check("R5 39 of 40 ticks", to_irq, 0);
    ticks(1);
    check("R5 40 ticks", to_irq, 1);

    pop("R1 order first");
    check("R7 read clears timeout", to_irq, 0);
    ticks(39);
    pulse_stop();
    ticks(39);
    check("R6 stop bit restart", to_irq, 0);
    ticks(1);
    check("R6 window after restart", to_irq, 1);
    rx_int_en = 0;
    @(negedge clk);
    check("R8 gated irqs", {avail_irq, to_irq}, 0);
    rx_int_en = 1;

    while (sb_q.size() > 0) pop("R1 drain order");
    check("R2 empty ready", data_ready, 0);
    ticks(50);
    check("R6 empty no timeout", to_irq, 0);

    // fill to 16 across the pointer wrap, trigger 14
    trig_sel = 2'd3;
    for (int i = 0; i < 13; i++) push(8'(i * 17 + 3));
    check("R3 13 below 14", avail_irq, 0);
    push(8'hA1);
    check("R3 at 14", avail_irq, 1);
    push(8'hA2); push(8'hA3);
    check("R1 full 16", fill, 16);
    trig_sel = 2'd2;
    @(negedge clk);
    check("R3 level 8", avail_irq, 1);
    push(8'hEE);
    check("R4 dropped keeps 16", fill, 16);
    check("R4 overrun set", overrun, 1);
    status_rd = 1; @(negedge clk); status_rd = 0;
    check("R4 overrun cleared", overrun, 0);

    word_len = 2'd0;
    pop("R1 wrap order");
    ticks(31);
    check("R5 5-bit 31 ticks", to_irq, 0);
    ticks(1);
    check("R5 5-bit 32 ticks", to_irq, 1);
    word_len = 2'd3;
    pop("R1 wrap order");
    ticks(43);
    check("R5 8-bit 43 ticks", to_irq, 0);
    ticks(1);
    check("R5 8-bit 44 ticks", to_irq, 1);

    fifo_clr = 1; @(negedge clk); fifo_clr = 0;
    sb_q.delete();
    check("R10 clear fill", fill, 0);
    check("R10 clear irqs", {avail_irq, to_irq}, 0);

    // single holding register
    fifo_en = 0; trig_sel = 2'd3;
    push(8'h5A);
    check("R9 one stored", fill, 1);
    check("R9 level 1", avail_irq, 1);
    push(8'h5B);
    check("R9 capacity 1", fill, 1);
    check("R9 overrun", overrun, 1);
    ticks(60);
    check("R9 no timeout", to_irq, 0);
    pop("R9 holds first");
    check("R9 empty", data_ready, 0);

    finish_run();
  end
endmodule